// File: doc/BRIEF.md
# Bit-Serial HEC Alignment Hunter

This block recovers byte and cell alignment from a serial ATM bit stream that arrives without any framing sync. Every received bit moves a 40-bit window forward by one position. The block treats the oldest 32 bits of the window as a candidate cell header and the newest 8 bits as its candidate header check byte. It tests the pair on every valid bit. Because each step moves the window by exactly one bit, every bit offset is tried, and the search does not assume that bytes are already aligned.

When a check byte matches, the block declares lock and fixes the bit phase at that point. From then on it counts bits to emit aligned bytes and counts bytes modulo 53 to flag the first header byte of each cell for the delineation logic that follows. A restart request drops lock and resumes the hunt from the current bit, reusing the window contents already held.

When the line supplies a sync pulse, a mode input bypasses the hunt. The pulse then sets the phase directly.

Top module: `hec_align_hunter`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `locked`, `byte_vld` and `cell_start` are 0.
- R2: The check byte is CRC-8 with generator x^8+x^2+x+1, processed first-received bit first from an all-zero start, then XORed with 0x55. It is computed over the 32 oldest of the 40 most recent valid bits, and a candidate matches when it equals the 8 newest bits, with the earliest bit as MSB.
- R3: In hunt mode (`sync_mode`=0) and while unlocked, a match is tested on every valid bit once at least 40 valid bits have arrived since reset. On a match, `locked` reads 1 from the cycle after the edge that took the last check bit.
- R4: A mismatching candidate does not lock. The next test uses the window moved by exactly one bit.
- R5: While locked, the block emits one byte for every 8 valid bits, MSB first. `byte_vld` is a one-cycle pulse that appears after the edge taking the byte's eighth bit. After a hunt lock, the first byte emitted is the one that follows the matched check byte.
- R6: `cell_start` is 1 together with `byte_vld` exactly for bytes whose index modulo 53 is 0. Index 0 is the first header byte of the matched window, so the byte following a hunt match has index 5.
- R7: A cycle with `bit_vld`=0 shifts nothing, advances no counter and gives `byte_vld`=0.
- R8: `restart` clears `locked` at its edge and overrides every other input. Any bit presented with it is still shifted into the window but is not tested. The hunt resumes on the next valid bit without refilling the window.
- R9: With `sync_mode`=1, no match test is made. A valid bit with `sync_pulse`=1 sets `locked`, and that bit becomes the MSB of byte index 0, even when the block is already locked. `sync_pulse` has no effect without `bit_vld`, or in hunt mode.
- R10: Once locked, `locked` stays 1 until `restart`, whatever the later window contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| restart | input | 1 | Drops lock and resumes the hunt |
| sync_mode | input | 1 | 1: phase taken from `sync_pulse`, hunt bypassed |
| sync_pulse | input | 1 | Marks the first header bit of a cell in sync mode |
| byte_out | output | 8 | Last aligned byte |
| byte_vld | output | 1 | One-cycle strobe for `byte_out` |
| cell_start | output | 1 | `byte_out` is the first header byte of a cell |
| locked | output | 1 | Alignment is held |

## Verification
If the window were shifted wrongly or the check byte were computed wrongly, the lock would come at the wrong bit or not at all. That error appears on `locked` in the cycle after the matching check bit. A wrong bit counter shows on the very next `byte_vld`, which arrives at the wrong cycle or carries a rotated value. A wrong byte index only becomes visible at the next `cell_start`, which can be up to 53 bytes after the lock. The bench therefore runs at least two full cells past each lock.

// File: rtl/hec_hunt_pkg.sv
package hec_hunt_pkg;
  localparam int HDR_BYTES = 4;
  localparam int CHK_W     = 8;
  localparam int HDR_W     = HDR_BYTES * 8;
  localparam int WIN_W     = HDR_W + CHK_W;
  localparam int CELL_BYTES = 53;
  localparam int IDX_W     = $clog2(CELL_BYTES);
  localparam logic [CHK_W-1:0] CHK_POLY  = 8'h07;
  localparam logic [CHK_W-1:0] CHK_COSET = 8'h55;
endpackage

// File: rtl/hec_crc_calc.sv
module hec_crc_calc #(
  parameter int DATA_W = 32,
  parameter int CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY = 8'h07,
  parameter logic [CRC_W-1:0] COSET = 8'h55
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  chk_o
);
  // One stage per data bit, oldest bit (MSB) entering first.
  logic [CRC_W-1:0] stage [DATA_W+1];
  assign stage[0] = '0;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_step
      logic fb;
      assign fb = stage[gi][CRC_W-1] ^ data_i[DATA_W-1-gi];
      assign stage[gi+1] = {stage[gi][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  endgenerate

  assign chk_o = stage[DATA_W] ^ COSET;
endmodule

// File: rtl/hec_win_shift.sv
module hec_win_shift #(
  parameter int WIN_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic             din_i,
  output logic [WIN_W-1:0] win_next_o,
  output logic             full_next_o
);
  localparam int FILL_W = $clog2(WIN_W + 1);

  logic [WIN_W-1:0]  sr_q, sr_d;
  logic [FILL_W-1:0] fill_q, fill_d;

  always_comb begin
    sr_d   = sr_q;
    fill_d = fill_q;
    if (vld_i) begin
      sr_d = {sr_q[WIN_W-2:0], din_i};
      if (fill_q != FILL_W'(WIN_W)) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      fill_q <= '0;
    end else if (vld_i) begin
      sr_q   <= sr_d;
      fill_q <= fill_d;
    end
  end

  assign win_next_o  = sr_d;
  assign full_next_o = vld_i && (fill_q >= FILL_W'(WIN_W - 1));

  a_r7_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(sr_q));
  a_r3_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_W'(WIN_W));
endmodule

// File: rtl/hec_phase_ctrl.sv
module hec_phase_ctrl
  import hec_hunt_pkg::*;
#(
  parameter int CELL_N = CELL_BYTES,
  parameter int HDR_N = HDR_BYTES,
  localparam int IW = $clog2(CELL_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic             restart_i,
  input  logic             sync_mode_i,
  input  logic             sync_pulse_i,
  input  logic             full_i,
  input  logic [CHK_W-1:0] chk_i,
  input  logic [7:0]       tail_i,
  output logic [7:0]       byte_o,
  output logic             byte_vld_o,
  output logic             cell_start_o,
  output logic             locked_o
);
  logic          locked_q, locked_d;
  logic [2:0]    bitc_q, bitc_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [7:0]    byte_q, byte_d;
  logic          bvld_q, bvld_d;
  logic          cs_q, cs_d;
  logic          hit;

  assign hit = full_i && (chk_i == tail_i);

  always_comb begin
    locked_d = locked_q;
    bitc_d   = bitc_q;
    idx_d    = idx_q;
    byte_d   = byte_q;
    bvld_d   = 1'b0;
    cs_d     = 1'b0;
    if (restart_i) begin
      locked_d = 1'b0;
    end else if (vld_i) begin
      if (sync_mode_i && sync_pulse_i) begin
        locked_d = 1'b1;
        bitc_d   = 3'd1;
        idx_d    = '0;
      end else if (locked_q) begin
        if (bitc_q == 3'd7) begin
          bitc_d = 3'd0;
          byte_d = tail_i;
          bvld_d = 1'b1;
          cs_d   = (idx_q == '0);
          idx_d  = (idx_q == IW'(CELL_N - 1)) ? '0 : idx_q + 1'b1;
        end else begin
          bitc_d = bitc_q + 3'd1;
        end
      end else if (!sync_mode_i && hit) begin
        locked_d = 1'b1;
        bitc_d   = 3'd0;
        idx_d    = IW'(HDR_N + 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      bitc_q   <= '0;
      idx_q    <= '0;
      byte_q   <= '0;
      bvld_q   <= 1'b0;
      cs_q     <= 1'b0;
    end else begin
      locked_q <= locked_d;
      bitc_q   <= bitc_d;
      idx_q    <= idx_d;
      byte_q   <= byte_d;
      bvld_q   <= bvld_d;
      cs_q     <= cs_d;
    end
  end

  assign byte_o       = byte_q;
  assign byte_vld_o   = bvld_q;
  assign cell_start_o = cs_q;
  assign locked_o     = locked_q;

  a_r7_byte_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    bvld_q |-> $past(vld_i));
  a_r5_no_byte_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_q |=> !bvld_q);
  a_r6_start_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> bvld_q);
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !locked_q);
  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !restart_i) |=> locked_q);
  a_r9_no_hunt_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_q && sync_mode_i && !(vld_i && sync_pulse_i)) |=> !locked_q);
  a_r3_lock_on_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(vld_i));
endmodule

// File: rtl/hec_align_hunter.sv
module hec_align_hunter
  import hec_hunt_pkg::*;
#(
  parameter int CELL_N = CELL_BYTES,
  parameter int HDR_N = HDR_BYTES,
  localparam int HW = HDR_N * 8,
  localparam int WW = HW + CHK_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_in,
  input  logic       bit_vld,
  input  logic       restart,
  input  logic       sync_mode,
  input  logic       sync_pulse,
  output logic [7:0] byte_out,
  output logic       byte_vld,
  output logic       cell_start,
  output logic       locked
);
  logic [WW-1:0]    win_next;
  logic             full_next;
  logic [CHK_W-1:0] chk;

  hec_win_shift #(.WIN_W(WW)) u_win (
    .clk(clk), .rst_n(rst_n), .vld_i(bit_vld), .din_i(bit_in),
    .win_next_o(win_next), .full_next_o(full_next)
  );

  hec_crc_calc #(.DATA_W(HW), .CRC_W(CHK_W), .POLY(CHK_POLY), .COSET(CHK_COSET)) u_crc (
    .data_i(win_next[WW-1:CHK_W]), .chk_o(chk)
  );

  hec_phase_ctrl #(.CELL_N(CELL_N), .HDR_N(HDR_N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .vld_i(bit_vld), .restart_i(restart),
    .sync_mode_i(sync_mode), .sync_pulse_i(sync_pulse), .full_i(full_next),
    .chk_i(chk), .tail_i(win_next[7:0]), .byte_o(byte_out),
    .byte_vld_o(byte_vld), .cell_start_o(cell_start), .locked_o(locked)
  );
endmodule

// File: tb/hec_align_hunter_test.sv
module hec_align_hunter_test;
  logic clk = 1'b0;
  logic rst_n, bit_in, bit_vld, restart, sync_mode, sync_pulse;
  logic [7:0] byte_out;
  logic byte_vld, cell_start, locked;

  int checks = 0, failures = 0;
  string cur_tag = "R1";

  // reference model state, built from the requirements
  logic [39:0] m_win;
  int   m_fill, m_bitc, m_idx, m_bytes, m_cells;
  logic m_lk, m_bv, m_cs;
  logic [7:0] m_byte;

  always #2 clk = ~clk;

  hec_align_hunter uut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld), .restart(restart),
    .sync_mode(sync_mode), .sync_pulse(sync_pulse), .byte_out(byte_out),
    .byte_vld(byte_vld), .cell_start(cell_start), .locked(locked)
  );

  function automatic logic [7:0] ref_chk(input logic [31:0] d);
    logic [7:0] c;
    logic fb;
    c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c ^ 8'h55;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(input logic v, b, rs, sm, sp);
    m_bv = 1'b0; m_cs = 1'b0;
    if (v) begin
      m_win = {m_win[38:0], b};
      if (m_fill < 40) m_fill++;
    end
    if (rs) m_lk = 1'b0;
    else if (v) begin
      if (sm && sp) begin
        m_lk = 1'b1; m_bitc = 1; m_idx = 0;
      end else if (m_lk) begin
        if (m_bitc == 7) begin
          m_bitc = 0; m_bv = 1'b1; m_byte = m_win[7:0]; m_cs = (m_idx == 0);
          m_idx = (m_idx == 52) ? 0 : m_idx + 1;
          m_bytes++;
          if (m_cs) m_cells++;
        end else m_bitc++;
      end else if (!sm && m_fill == 40 && ref_chk(m_win[39:8]) == m_win[7:0]) begin
        m_lk = 1'b1; m_bitc = 0; m_idx = 5;
      end
    end
  endtask

  task automatic cyc(input logic v, b, rs, sm, sp);
    @(negedge clk);
    bit_vld = v; bit_in = b; restart = rs; sync_mode = sm; sync_pulse = sp;
    @(posedge clk);
    #1;
    model_step(v, b, rs, sm, sp);
    chk(locked == m_lk, cur_tag, "locked", locked, m_lk);
    chk(byte_vld == m_bv, cur_tag, "byte_vld", byte_vld, m_bv);
    chk(cell_start == m_cs, cur_tag, "cell_start", cell_start, m_cs);
    if (m_bv) chk(byte_out == m_byte, cur_tag, "byte_out", byte_out, m_byte);
  endtask

  task automatic send_byte(input logic [7:0] x, input logic sm, input int gap);
    for (int i = 7; i >= 0; i--) begin
      cyc(1'b1, x[i], 1'b0, sm, 1'($urandom % 2));
      if (gap != 0 && (i % gap) == 0) cyc(1'b0, 1'($urandom % 2), 1'b0, sm, 1'b1);
    end
  endtask

  task automatic send_cell(input bit good, input bit zero, input int gap);
    logic [31:0] h;
    logic [7:0] c;
    h = zero ? 32'h0 : $urandom;
    c = ref_chk(h) ^ (good ? 8'h00 : 8'h01);
    for (int k = 3; k >= 0; k--) send_byte(h[8*k +: 8], 1'b0, gap);
    send_byte(c, 1'b0, gap);
    for (int k = 0; k < 48; k++) send_byte(zero ? 8'h00 : 8'($urandom), 1'b0, gap);
  endtask

  // R1: reset state
  task automatic t_reset();
    cur_tag = "R1";
    rst_n = 1'b0; bit_in = 0; bit_vld = 0; restart = 0; sync_mode = 0; sync_pulse = 0;
    m_win = '0; m_fill = 0; m_bitc = 0; m_idx = 0; m_lk = 0; m_bv = 0; m_cs = 0;
    m_byte = 0; m_bytes = 0; m_cells = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(locked == 0 && byte_vld == 0 && cell_start == 0, "R1", "outputs in reset",
        {locked, byte_vld, cell_start}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // R2 R3 R4 R5 R6: hunt from an arbitrary bit offset, sync_pulse ignored (R9)
  task automatic t_hunt(input int skew);
    int b0, c0;
    cur_tag = "R3";
    for (int i = 0; i < skew; i++) cyc(1'b1, 1'($urandom % 2), 1'b0, 1'b0, 1'b1);
    b0 = m_bytes; c0 = m_cells;
    for (int k = 0; k < 3; k++) send_cell(1'b1, 1'b0, 0);
    chk(locked == 1'b1, "R2", "lock after valid check byte", locked, 1);
    chk(m_bytes - b0 >= 100, "R5", "bytes emitted", m_bytes - b0, 100);
    chk(m_cells - c0 >= 2, "R6", "cell starts seen", m_cells - c0, 2);
  endtask

  // R8: restart drops lock and hunt resumes
  task automatic t_restart();
    cur_tag = "R8";
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(locked == 1'b0, "R8", "locked after restart", locked, 0);
    for (int k = 0; k < 3; k++) send_cell(1'b1, 1'b0, 0);
    chk(locked == 1'b1, "R8", "relock after restart", locked, 1);
  endtask

  // R4 R10: corrupted check byte does not lock; does not unlock once locked
  task automatic t_corrupt();
    cur_tag = "R4";
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    send_cell(1'b0, 1'b1, 0);
    chk(locked == m_lk, "R4", "lock state after bad cell", locked, m_lk);
    send_cell(1'b1, 1'b0, 0);
    send_cell(1'b1, 1'b0, 0);
    chk(locked == 1'b1, "R4", "lock after good cell", locked, 1);
    cur_tag = "R10";
    send_cell(1'b0, 1'b0, 0);
    chk(locked == 1'b1, "R10", "lock kept over bad cell", locked, 1);
  endtask

  // R7: idle cycles between bits
  task automatic t_gaps();
    int b0;
    cur_tag = "R7";
    b0 = m_bytes;
    for (int k = 0; k < 2; k++) send_cell(1'b1, 1'b0, 3);
    chk(m_bytes - b0 == 106, "R7", "bytes over gapped cells", m_bytes - b0, 106);
  endtask

  // R9: sync mode bypasses the hunt
  task automatic t_sync();
    cur_tag = "R9";
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 300; i++) cyc(1'b1, 1'($urandom % 2), 1'b0, 1'b1, 1'b0);
    chk(locked == 1'b0, "R9", "no hunt lock in sync mode", locked, 0);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    chk(locked == 1'b0, "R9", "pulse without valid ignored", locked, 0);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    chk(locked == 1'b1, "R9", "lock on pulse", locked, 1);
    for (int i = 0; i < 7; i++) cyc(1'b1, 1'($urandom % 2), 1'b0, 1'b1, 1'b0);
    chk(cell_start == 1'b1, "R9", "first byte is cell start", cell_start, 1);
    for (int i = 0; i < 900; i++) cyc(1'b1, 1'($urandom % 2), 1'b0, 1'b1, 1'(i == 333));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_hunt(3);
    t_restart();
    t_corrupt();
    t_gaps();
    t_sync();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule